// File: doc/BRIEF.md
# Supervisor Domain Interrupt Controller Selector

This block sits beside one hart and picks which of several per-domain external interrupt controllers is currently live for supervisor and guest software. Controllers are numbered 1 to `NUM_CTRL` (at most 63). Parameters state, for each one, whether it is present, whether it is message-signalled or wired, and how many guest interrupt files it has. A machine-mode configuration register holds a 6-bit selection. Machine software writes the number of the domain it is about to run into that register.

From the registered selection, the block forwards the chosen controller's supervisor-level pending line and, for a message-signalled controller, its guest pending vector. Guest bits beyond that controller's own file count are masked. It also tells indirect CSR access logic which controller to steer to. When the selection is zero or names a controller that is absent, nothing is forwarded. The three state-enable controls that expose interrupt-controller CSRs to lower modes are then forced off. The outputs are combinational from the selection register, so a write takes effect in the cycle after it.

Top module: `dom_irq_select`

## Requirements
- R1: A synchronous active-high reset clears the selection to 0. After reset, `cfg_rdata` is 0 and every pending, steering and enable output is 0.
- R2: A write whose low six bits lie between 0 and the highest implemented controller number, inclusive, loads the selection. A larger value leaves the selection unchanged.
- R3: `cfg_rdata[5:0]` returns the selection and `cfg_rdata[31:6]` always reads 0, whatever was written to those bits.
- R4: While the selection is 0 or names an unimplemented controller, `s_ext_pend`, all of `g_ext_pend` and `ind_valid` are 0, and `ind_id` is 0.
- R5: `stateen_eff` equals `stateen_in` while an implemented controller is selected, and is 0 otherwise.
- R6: With a message-signalled controller k selected, `s_ext_pend` follows `ctl_s_pend[k-1]`. `g_ext_pend[j]` follows `ctl_g_pend[(k-1)*GF_MAX + j]`. `ind_valid` is 1 and `ind_id` equals k.
- R7: With a wired controller k selected, `s_ext_pend` follows `ctl_s_pend[k-1]`, `g_ext_pend` is 0 and `ind_valid` is 0.
- R8: Bit j of `g_ext_pend` is 0 whenever j is at or above the selected controller's guest file count.
- R9: A new selection changes the outputs on the first clock edge after the write cycle. A change on the pending or enable inputs shows on the outputs in the same cycle.
- R10: With no controller implemented, the selection is fixed at 0 and every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data; selection in bits [5:0] |
| cfg_rdata | output | 32 | Configuration readback |
| ctl_s_pend | input | NUM_CTRL | Supervisor pending line of controller k on bit k-1 |
| ctl_g_pend | input | NUM_CTRL*GF_MAX | Guest file pending lines, GF_MAX bits per controller |
| stateen_in | input | 3 | Raw interrupt-controller state-enable controls |
| stateen_eff | output | 3 | State-enable controls after gating |
| s_ext_pend | output | 1 | Supervisor external interrupt pending |
| g_ext_pend | output | GF_MAX | Guest external interrupt pending vector |
| ind_valid | output | 1 | Indirect CSR accesses go to a controller |
| ind_id | output | 6 | Controller that indirect CSR accesses go to |

## Verification
Two cases are hard to reach. One is a selection that is in range but names a missing controller. The other is a controller whose guest file count is smaller than the vector width, because random traffic seldom holds the selection there while the upper guest inputs are active. The bench writes every selection value in turn, including the missing controller 4 and the rejected values 6, 7 and 63. At each selection it drives several cycles of random pending and enable traffic, then an all-ones guest pattern to expose the masked bits. A second instance with no controllers covers the hardwired-zero variant.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int SEL_W = 6;
  localparam int CFG_W = 32;
  localparam int SEN_W = 3;
  localparam int MAX_CTRL = (1 << SEL_W) - 1;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic s_pend;
    logic any_active;
    logic steer;
  } route_flags_t;
endpackage

// File: rtl/dis_cfg_reg.sv
module dis_cfg_reg
  import dis_pkg::*;
#(
  parameter int MAX_SEL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  sel_t wsel,
  output sel_t sel
);
  generate
    if (MAX_SEL == 0) begin : g_fixed
      logic unused_wr;
      assign unused_wr = we ^ (^wsel) ^ clk ^ rst;
      assign sel = '0;
    end else begin : g_reg
      localparam sel_t MAX_V = sel_t'(MAX_SEL);
      sel_t sel_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sel_q <= '0;
        end else if (we && (wsel <= MAX_V)) begin
          sel_q <= wsel;
        end
      end
      assign sel = sel_q;
    end
  endgenerate
endmodule

// File: rtl/dis_route.sv
module dis_route
  import dis_pkg::*;
#(
  parameter int                      NUM_CTRL  = 5,
  parameter int                      GF_MAX    = 8,
  parameter logic [NUM_CTRL-1:0]     CTRL_IMPL = '1,
  parameter logic [NUM_CTRL-1:0]     CTRL_MSI  = '0,
  parameter logic [NUM_CTRL*6-1:0]   CTRL_NGF  = '0
) (
  input  sel_t                       sel,
  input  logic [NUM_CTRL-1:0]        s_in,
  input  logic [NUM_CTRL*GF_MAX-1:0] g_in,
  output route_flags_t               flags,
  output logic [GF_MAX-1:0]          g_pend
);
  function automatic logic [GF_MAX-1:0] file_mask(input int n);
    logic [GF_MAX-1:0] m;
    for (int j = 0; j < GF_MAX; j++) begin
      m[j] = (j < n);
    end
    return m;
  endfunction

  logic [NUM_CTRL-1:0] hit;
  logic [NUM_CTRL-1:0] msi_hit;
  logic [GF_MAX-1:0]   g_part [NUM_CTRL];

  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      localparam sel_t              ID    = sel_t'(i + 1);
      localparam int                NFILE = int'(CTRL_NGF[i*6 +: 6]);
      localparam logic [GF_MAX-1:0] MASK  = CTRL_MSI[i] ? file_mask(NFILE) : '0;
      if (CTRL_IMPL[i]) begin : g_present
        assign hit[i] = (sel == ID);
      end else begin : g_absent
        assign hit[i] = 1'b0;
      end
      assign msi_hit[i] = hit[i] & CTRL_MSI[i];
      assign g_part[i]  = g_in[i*GF_MAX +: GF_MAX] & MASK & {GF_MAX{msi_hit[i]}};
    end
  endgenerate

  always_comb begin
    g_pend = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      g_pend = g_pend | g_part[i];
    end
  end

  assign flags.s_pend     = |(hit & s_in);
  assign flags.any_active = |hit;
  assign flags.steer      = |msi_hit;
endmodule

// File: rtl/dis_gate.sv
module dis_gate
  import dis_pkg::*;
(
  input  route_flags_t     flags,
  input  sel_t             sel,
  input  logic [SEN_W-1:0] stateen_in,
  output logic [SEN_W-1:0] stateen_eff,
  output logic             ind_valid,
  output sel_t             ind_id
);
  assign stateen_eff = stateen_in & {SEN_W{flags.any_active}};
  assign ind_valid   = flags.steer;
  assign ind_id      = flags.steer ? sel : '0;
endmodule

// File: rtl/dom_irq_select.sv
module dom_irq_select
  import dis_pkg::*;
#(
  parameter int                    NUM_CTRL  = 5,
  parameter int                    GF_MAX    = 8,
  parameter logic [NUM_CTRL-1:0]   CTRL_IMPL = 5'b10111,
  parameter logic [NUM_CTRL-1:0]   CTRL_MSI  = 5'b00101,
  parameter logic [NUM_CTRL*6-1:0] CTRL_NGF  = 30'h0000_3008
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  input  logic [NUM_CTRL-1:0]        ctl_s_pend,
  input  logic [NUM_CTRL*GF_MAX-1:0] ctl_g_pend,
  input  logic [2:0]                 stateen_in,
  output logic [2:0]                 stateen_eff,
  output logic                       s_ext_pend,
  output logic [GF_MAX-1:0]          g_ext_pend,
  output logic                       ind_valid,
  output logic [5:0]                 ind_id
);
  function automatic int highest_impl(input logic [NUM_CTRL-1:0] impl);
    int h;
    h = 0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (impl[i]) h = i + 1;
    end
    return h;
  endfunction

  localparam int MAX_SEL = highest_impl(CTRL_IMPL);

  sel_t         sel;
  route_flags_t flags;
  logic         unused_hi;

  assign unused_hi = ^cfg_wdata[CFG_W-1:SEL_W];

  dis_cfg_reg #(.MAX_SEL(MAX_SEL)) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wsel (cfg_wdata[SEL_W-1:0]),
    .sel  (sel)
  );

  dis_route #(
    .NUM_CTRL  (NUM_CTRL),
    .GF_MAX    (GF_MAX),
    .CTRL_IMPL (CTRL_IMPL),
    .CTRL_MSI  (CTRL_MSI),
    .CTRL_NGF  (CTRL_NGF)
  ) u_route (
    .sel    (sel),
    .s_in   (ctl_s_pend),
    .g_in   (ctl_g_pend),
    .flags  (flags),
    .g_pend (g_ext_pend)
  );

  dis_gate u_gate (
    .flags       (flags),
    .sel         (sel),
    .stateen_in  (stateen_in),
    .stateen_eff (stateen_eff),
    .ind_valid   (ind_valid),
    .ind_id      (ind_id)
  );

  assign s_ext_pend = flags.s_pend;
  assign cfg_rdata  = {{(CFG_W-SEL_W){1'b0}}, sel};
endmodule

// File: rtl/dom_irq_select_chk.sv
module dom_irq_select_chk #(
  parameter int MAX_SEL = 1,
  parameter int GF_MAX  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic [2:0]        stateen_in,
  input logic [2:0]        stateen_eff,
  input logic [GF_MAX-1:0] g_ext_pend,
  input logic              ind_valid,
  input logic [5:0]        ind_id
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cfg_rdata == 32'h0)); // R1

  AST_ILLEGAL_HELD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (int'(cfg_wdata[5:0]) > MAX_SEL)) |=> $stable(cfg_rdata)); // R2

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(cfg_rdata[5:0]) <= MAX_SEL); // R2

  AST_STATEEN_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (stateen_eff & ~stateen_in) == 3'b000); // R5

  AST_GUEST_NEEDS_STEER: assert property (@(posedge clk) disable iff (rst)
    !ind_valid |-> (g_ext_pend == '0)); // R7

  AST_STEER_MATCHES_SEL: assert property (@(posedge clk) disable iff (rst)
    ind_valid |-> (ind_id == cfg_rdata[5:0] && ind_id != 6'd0)); // R6
endmodule

bind dom_irq_select dom_irq_select_chk #(.MAX_SEL(MAX_SEL), .GF_MAX(GF_MAX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .stateen_in  (stateen_in),
  .stateen_eff (stateen_eff),
  .g_ext_pend  (g_ext_pend),
  .ind_valid   (ind_valid),
  .ind_id      (ind_id)
);

// File: tb/dom_irq_select_test.sv
`timescale 1ns/1ps
module dom_irq_select_test;
  localparam int NC = 5;
  localparam int GF = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata, e_rdata;
  logic [NC-1:0] s_in;
  logic [NC*GF-1:0] g_in;
  logic [2:0]    st_in, st_eff, e_st_eff;
  logic          s_pend, e_s_pend, ind_valid, e_ind_valid;
  logic [GF-1:0] g_pend, e_g_pend;
  logic [5:0]    ind_id, e_ind_id;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Bench view of the controllers: present, message-signalled, guest file count
  int present [1:NC] = '{1, 1, 1, 0, 1};
  int msgsig  [1:NC] = '{1, 0, 1, 0, 0};
  int nfiles  [1:NC] = '{8, 0, 3, 0, 0};
  int msel;
  int esel;

  always #2.5 clk = ~clk;

  dom_irq_select uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctl_s_pend(s_in), .ctl_g_pend(g_in), .stateen_in(st_in), .stateen_eff(st_eff),
    .s_ext_pend(s_pend), .g_ext_pend(g_pend), .ind_valid(ind_valid), .ind_id(ind_id)
  );

  dom_irq_select #(.NUM_CTRL(2), .GF_MAX(GF), .CTRL_IMPL(2'b00), .CTRL_MSI(2'b00),
                   .CTRL_NGF(12'h0)) uut_empty (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(e_rdata),
    .ctl_s_pend(s_in[1:0]), .ctl_g_pend(g_in[2*GF-1:0]), .stateen_in(st_in),
    .stateen_eff(e_st_eff), .s_ext_pend(e_s_pend), .g_ext_pend(e_g_pend),
    .ind_valid(e_ind_valid), .ind_id(e_ind_id)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h (sel=%0d)", req, act, exp, msel);
    end
  endtask

  task automatic check_all();
    bit act;
    logic [GF-1:0] eg;
    vectors++;
    act = (msel >= 1 && msel <= NC) ? (present[msel] != 0) : 1'b0;
    eg = '0;
    if (act && msgsig[msel] != 0)
      for (int j = 0; j < GF; j++)
        if (j < nfiles[msel]) eg[j] = g_in[(msel-1)*GF + j];
    cmp("R2/R3 readback", cfg_rdata, msel);
    cmp("R4/R6/R7 s_ext_pend", {31'b0, s_pend}, act ? s_in[msel-1] : 0);
    cmp("R6/R8 g_ext_pend", {24'b0, g_pend}, {24'b0, eg});
    cmp("R5 stateen_eff", {29'b0, st_eff}, act ? {29'b0, st_in} : 0);
    cmp("R6/R7 ind_valid", {31'b0, ind_valid}, (act && msgsig[msel] != 0) ? 1 : 0);
    cmp("R6 ind_id", {26'b0, ind_id}, (act && msgsig[msel] != 0) ? msel : 0);
    // R10: controller-less instance stays at zero
    cmp("R10 empty readback", e_rdata, esel);
    cmp("R10 empty outputs", {e_s_pend, e_g_pend, e_st_eff, e_ind_valid, e_ind_id}, 0);
  endtask

  // One cycle: drive at the falling edge, model the register at the rising edge, check at the next falling edge
  task automatic cyc(input logic we, input logic [31:0] wd, input logic [NC-1:0] s,
                     input logic [NC*GF-1:0] g, input logic [2:0] st, input logic r);
    cfg_we = we; cfg_wdata = wd; s_in = s; g_in = g; st_in = st; rst = r;
    @(posedge clk);
    if (r) msel = 0;
    else if (we && int'(wd[5:0]) <= 5) msel = int'(wd[5:0]);
    esel = 0;
    @(negedge clk);
    check_all();
  endtask

  task automatic rnd_cycles(input int n);
    logic [31:0] a, b, c;
    for (int k = 0; k < n; k++) begin
      a = $urandom; b = $urandom; c = $urandom;
      cyc(1'b0, a, a[NC-1:0], {b[7:0], c}, a[10:8], 1'b0);
    end
  endtask

  initial begin
    int sels [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 63, 1};
    msel = 0; esel = 0;
    cfg_we = 0; cfg_wdata = 0; s_in = 0; g_in = 0; st_in = 0; rst = 1;
    @(negedge clk);
    // R1: reset state with all inputs active
    cyc(1'b0, 0, '1, '1, 3'b111, 1'b1);
    cyc(1'b0, 0, '1, '1, 3'b111, 1'b0);
    // R2, R4..R7, R9: sweep every selection value, then random traffic
    foreach (sels[i]) begin
      cyc(1'b1, sels[i], '1, '1, 3'b101, 1'b0);
      rnd_cycles(6);
      // R8: all guest inputs high exposes the file-count mask
      cyc(1'b0, 0, '1, '1, 3'b111, 1'b0);
    end
    // R2: legal value then out-of-range value is not retained
    cyc(1'b1, 32'd3, '0, '0, 3'b010, 1'b0);
    cyc(1'b1, 32'd6, '0, '1, 3'b010, 1'b0);
    // R3: high bits of write data never read back
    cyc(1'b1, 32'hFFFF_FFC1, 5'b00001, '1, 3'b110, 1'b0);
    // R9: input change visible in the same cycle, no write
    cyc(1'b0, 0, 5'b00000, '0, 3'b000, 1'b0);
    cyc(1'b0, 0, 5'b00001, 40'h00_0000_0080, 3'b011, 1'b0);
    // R1: reset from a live selection
    cyc(1'b1, 32'd5, '1, '1, 3'b111, 1'b0);
    cyc(1'b0, 0, '1, '1, 3'b111, 1'b1);
    cyc(1'b0, 0, '1, '1, 3'b111, 1'b0);
    rnd_cycles(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule